// File: doc/BRIEF.md
# Key-Sequenced Watchdog Reset Controller

This block is a watchdog timer that drives a reset request for the chip. It is built on a count-up counter, 64 bits wide by default, that is split into a low half and a high half for register access. Software first selects watchdog operation in a global control register and takes both counter halves out of reset. It then clears the counter and period registers and arms the watchdog by writing two fixed key values, in order, to the upper half of the watchdog control register. The enable bit must be set for the first key to count.

Once armed, the counter advances one step per clock cycle. Software services the watchdog by writing the same two keys again, which returns the counter to zero. If the counter reaches the programmed period before a service, the block raises its reset request. It also raises the request at once if software writes any other key value while the watchdog is armed. The request stays asserted until the external reset input is applied.

The register port is a plain single-cycle bus. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` and has no handshake. There is no stream interface, so there is no valid/ready pair and no back-pressure.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, every register reads zero, the watchdog state is inactive and `reset_req` is low.
- R2: The global control register at offset 0x24 holds release bits 1:0 and a mode field at bits 3:2. Key writes act only when the mode field is 2 and both release bits are 1; under any other value they leave the state unchanged.
- R3: The enable bit (bit 14 of offset 0x28) can only be set. A write of 0 to it is ignored. The arming key is ignored while the enable is clear, counting the enable carried by that same write.
- R4: From inactive, key 0xA5C6 (bits 31:16 of offset 0x28) moves to pre-active (state code 1). From pre-active, key 0xDA7E moves to active (state code 2). Every other key leaves pre-active unchanged.
- R5: While active or service-pending, and until the reset request rises, the counter advances by one on each clock edge, wrapping at its width. Its low half reads at 0x10 and its high half at 0x14.
- R6: On the clock edge where an armed counter equals the period (low half at 0x18, high half at 0x1C), `reset_req` rises. With the counter at 0 when arming completes, this is the (period+1)-th edge after the arming write.
- R7: A control write while active or service-pending whose key is neither 0xA5C6 nor 0xDA7E raises `reset_req` on that write's own edge.
- R8: In active, key 0xA5C6 moves to service-pending (state code 3) and leaves the counter running. In service-pending, key 0xDA7E returns to active and sets the counter to zero on that edge.
- R9: Once raised, `reset_req` stays high whatever is written, until `rst_n` is applied.
- R10: A read of offset 0x28 returns the enable in bit 14 and the state code in bits 13:12. All other bits, including the key field, read as zero.
- R11: While active or service-pending, writes to the counter, period and global control registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only way to clear the enable and the reset request |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| reset_req | output | 1 | Sticky reset request |

## Verification
The bench builds the block with CNT_W = 8, which gives 4-bit halves. At that width every one of the 256 period values can be swept to its timeout, and wrap of the counter at full scale falls inside the sweep. The bench also sweeps all 16 values of the global control register against the arming sequence, and applies a spread of 32 invalid keys in both the active and the service-pending states. The timing of service and of a service-pending state without a confirm is checked against cycle counts computed in the bench.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [5:0] OFS_CNT_LO = 6'h10;
  localparam logic [5:0] OFS_CNT_HI = 6'h14;
  localparam logic [5:0] OFS_PRD_LO = 6'h18;
  localparam logic [5:0] OFS_PRD_HI = 6'h1C;
  localparam logic [5:0] OFS_GLB    = 6'h24;
  localparam logic [5:0] OFS_CTL    = 6'h28;

  localparam logic [15:0] KEY_ARM     = 16'hA5C6;
  localparam logic [15:0] KEY_CONFIRM = 16'hDA7E;

  localparam int unsigned EN_BIT    = 14;
  localparam int unsigned STATE_LSB = 12;
  localparam int unsigned KEY_LSB   = 16;
  localparam logic [1:0]  MODE_WDOG = 2'd2;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_PRE   = 2'd1,
    WD_ARMED = 2'd2,
    WD_SVC   = 2'd3
  } wd_state_e;
endpackage

// File: rtl/keyed_wdog_keyfsm.sv
module keyed_wdog_keyfsm
  import keyed_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_ok,
  input  logic       ctl_wr,
  input  logic       wr_en_bit,
  input  logic [15:0] wr_key,
  output wd_state_e  state,
  output logic       en,
  output logic       svc_clr,
  output logic       bad_key
);
  wd_state_e state_d;
  logic      en_d;

  always_comb begin
    state_d = state;
    svc_clr = 1'b0;
    bad_key = 1'b0;
    en_d    = en | (ctl_wr & wr_en_bit);
    if (ctl_wr && cfg_ok) begin
      unique case (state)
        WD_IDLE:  if (en_d && wr_key == KEY_ARM) state_d = WD_PRE;
        WD_PRE:   if (wr_key == KEY_CONFIRM) state_d = WD_ARMED;
        WD_ARMED: begin
          if (wr_key == KEY_ARM) state_d = WD_SVC;
          else if (wr_key != KEY_CONFIRM) bad_key = 1'b1;
        end
        WD_SVC: begin
          if (wr_key == KEY_CONFIRM) begin
            state_d = WD_ARMED;
            svc_clr = 1'b1;
          end else if (wr_key != KEY_ARM) begin
            bad_key = 1'b1;
          end
        end
        default: state_d = WD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WD_IDLE;
      en    <= 1'b0;
    end else begin
      state <= state_d;
      en    <= en_d;
    end
  end
endmodule

// File: rtl/keyed_wdog_count.sv
module keyed_wdog_count #(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cnt_we,
  input  logic [1:0]         prd_we,
  input  logic [CNT_W/2-1:0] wdata,
  input  logic               run,
  input  logic               clr,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   prd,
  output logic               hit
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_mask, prd_mask, wfill, cnt_base, cnt_d, prd_d;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign cnt_mask[h*HALF_W +: HALF_W] = {HALF_W{cnt_we[h]}};
    assign prd_mask[h*HALF_W +: HALF_W] = {HALF_W{prd_we[h]}};
    assign wfill[h*HALF_W +: HALF_W]    = wdata;
  end

  always_comb begin
    if (clr)      cnt_base = '0;
    else if (run) cnt_base = cnt + CNT_W'(1);
    else          cnt_base = cnt;
    cnt_d = (cnt_base & ~cnt_mask) | (wfill & cnt_mask);
    prd_d = (prd & ~prd_mask) | (wfill & prd_mask);
  end

  assign hit = (cnt == prd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      prd <= '0;
    end else begin
      cnt <= cnt_d;
      prd <= prd_d;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [3:0]       glb;
  wd_state_e        state;
  logic             en, svc_clr, bad_key, hit;
  logic             armed, cfg_ok, ctl_wr, run, open_wr;
  logic [1:0]       cnt_we, prd_we;
  logic [CNT_W-1:0] cnt, prd;

  assign armed   = (state == WD_ARMED) || (state == WD_SVC);
  assign cfg_ok  = (glb[3:2] == MODE_WDOG) && (&glb[1:0]);
  assign ctl_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
  assign open_wr = bus_wr && !armed;
  assign run     = armed && !reset_req;

  assign cnt_we = {open_wr && (bus_addr == ADDR_W'(OFS_CNT_HI)),
                   open_wr && (bus_addr == ADDR_W'(OFS_CNT_LO))};
  assign prd_we = {open_wr && (bus_addr == ADDR_W'(OFS_PRD_HI)),
                   open_wr && (bus_addr == ADDR_W'(OFS_PRD_LO))};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb       <= '0;
      reset_req <= 1'b0;
    end else begin
      if (open_wr && bus_addr == ADDR_W'(OFS_GLB)) glb <= bus_wdata[3:0];
      if ((armed && hit) || bad_key) reset_req <= 1'b1;
    end
  end

  keyed_wdog_keyfsm u_keyfsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_ok    (cfg_ok),
    .ctl_wr    (ctl_wr),
    .wr_en_bit (bus_wdata[EN_BIT]),
    .wr_key    (bus_wdata[KEY_LSB +: 16]),
    .state     (state),
    .en        (en),
    .svc_clr   (svc_clr),
    .bad_key   (bad_key)
  );

  keyed_wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_we (cnt_we),
    .prd_we (prd_we),
    .wdata  (bus_wdata[HALF_W-1:0]),
    .run    (run),
    .clr    (svc_clr),
    .cnt    (cnt),
    .prd    (prd),
    .hit    (hit)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CNT_LO))      bus_rdata = DATA_W'(cnt[HALF_W-1:0]);
    else if (bus_addr == ADDR_W'(OFS_CNT_HI)) bus_rdata = DATA_W'(cnt[CNT_W-1:HALF_W]);
    else if (bus_addr == ADDR_W'(OFS_PRD_LO)) bus_rdata = DATA_W'(prd[HALF_W-1:0]);
    else if (bus_addr == ADDR_W'(OFS_PRD_HI)) bus_rdata = DATA_W'(prd[CNT_W-1:HALF_W]);
    else if (bus_addr == ADDR_W'(OFS_GLB))    bus_rdata = DATA_W'(glb);
    else if (bus_addr == ADDR_W'(OFS_CTL)) begin
      bus_rdata[EN_BIT]              = en;
      bus_rdata[STATE_LSB +: 2]      = state;
    end
  end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              reset_req,
  input logic              wd_en,
  input logic [1:0]        wd_state
);
  logic ctl_w, wd_armed;
  logic [15:0] key;
  assign ctl_w    = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
  assign key      = bus_wdata[KEY_LSB +: 16];
  assign wd_armed = (wd_state == 2'd2) || (wd_state == 2'd3);

  assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);

  assert_en_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |=> wd_en);

  assert_bad_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && wd_armed && key != KEY_ARM && key != KEY_CONFIRM) |=> reset_req);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_state == 2'd0 && !(ctl_w && key == KEY_ARM)) |=> (wd_state == 2'd0));

  assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(wd_armed));
endmodule

bind keyed_wdog keyed_wdog_chk #(.ADDR_W(ADDR_W)) u_keyed_wdog_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .reset_req (reset_req),
  .wd_en     (en),
  .wd_state  (state)
);

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;
  localparam int CNT_W = 8;
  localparam logic [5:0] A_CLO = 6'h10, A_CHI = 6'h14, A_PLO = 6'h18,
                         A_PHI = 6'h1C, A_GLB = 6'h24, A_CTL = 6'h28;
  localparam logic [31:0] EN = 32'h0000_4000;
  localparam logic [15:0] K_ARM = 16'hA5C6, K_CNF = 16'hDA7E;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, reset_req;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int nvec = 0, nfail = 0;

  always #2.5 clk = ~clk;

  keyed_wdog #(.CNT_W(CNT_W), .ADDR_W(6)) u_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic key(input logic [15:0] k);
    wr(A_CTL, {k, 16'h0} | EN);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic arm(input int p);
    wr(A_GLB, 32'hB); wr(A_CLO, 0); wr(A_CHI, 0);
    wr(A_PLO, p & 15); wr(A_PHI, (p >> 4) & 15);
    wr(A_CTL, EN); key(K_ARM); key(K_CNF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R1 reset state
    chk("R1 req", {31'b0, reset_req}, 0);
    foreach (A_LIST[i]) begin rd(A_LIST[i], d); chk("R1 reg", d, 0); end

    // R2 exhaustive global control values
    for (int g = 0; g < 16; g++) begin
      do_reset();
      wr(A_GLB, g); wr(A_CTL, EN); key(K_ARM); key(K_CNF);
      rd(A_CTL, d);
      chk("R2 cfg", d, (g == 11) ? 32'h6000 : 32'h4000);
    end

    // R3 enable sticky and gating of arm key
    do_reset(); wr(A_GLB, 32'hB);
    wr(A_CTL, {K_ARM, 16'h0}); rd(A_CTL, d); chk("R3 no-en", d, 0);
    wr(A_CTL, EN); rd(A_CTL, d); chk("R3 set", d, 32'h4000);
    wr(A_CTL, 0);  rd(A_CTL, d); chk("R3 sticky", d, 32'h4000);
    do_reset(); wr(A_GLB, 32'hB); key(K_ARM); rd(A_CTL, d);
    chk("R3 same-write", d, 32'h5000);

    // R4 pre-active ignores other keys; R10 read format
    key(16'h1111); rd(A_CTL, d); chk("R4 pre-ignore", d, 32'h5000);
    key(K_ARM);    rd(A_CTL, d); chk("R4 pre-arm", d, 32'h5000);
    key(K_CNF);    rd(A_CTL, d); chk("R10 active", d, 32'h6000);
    chk("R4 no-req", {31'b0, reset_req}, 0);

    // R5 R6 timeout sweep over every period
    for (int p = 0; p < 256; p++) begin
      do_reset(); arm(p);
      idle(p); chk("R6 early", {31'b0, reset_req}, 0);
      idle(1); chk("R6 fire", {31'b0, reset_req}, 1);
      rd(A_CLO, d); chk("R5 cnt lo", d, (p + 1) & 15);
      rd(A_CHI, d); chk("R5 cnt hi", d, ((p + 1) >> 4) & 15);
    end

    // R11 locked registers while armed
    do_reset(); arm(200);
    wr(A_PLO, 3); rd(A_PLO, d); chk("R11 prd", d, 200 & 15);
    wr(A_GLB, 0); rd(A_GLB, d); chk("R11 glb", d, 32'hB);
    wr(A_CLO, 15); rd(A_CLO, d); chk("R11 cnt", d, 3);

    // R8 service sequence
    do_reset(); arm(20); idle(4); key(K_ARM);
    rd(A_CTL, d); chk("R8 pending", d, 32'h7000);
    rd(A_CLO, d); chk("R8 no-clear", d, 5);
    key(K_CNF);
    rd(A_CTL, d); chk("R8 back", d, 32'h6000);
    rd(A_CLO, d); chk("R8 clear", d, 0);
    idle(20); chk("R8 early", {31'b0, reset_req}, 0);
    idle(1);  chk("R8 fire", {31'b0, reset_req}, 1);

    // R8 pending alone does not extend the deadline
    do_reset(); arm(20); idle(4); key(K_ARM);
    idle(15); chk("R8 pend early", {31'b0, reset_req}, 0);
    idle(1);  chk("R8 pend fire", {31'b0, reset_req}, 1);

    // R7 invalid keys in active and service-pending
    for (int i = 0; i < 32; i++) begin
      logic [15:0] k;
      k = 16'(i * 16'h0851) ^ 16'h0013;
      do_reset(); arm(200); idle(2);
      if (i % 2 == 1) key(K_ARM);
      chk("R7 before", {31'b0, reset_req}, 0);
      key(k);
      chk("R7 bad key", {31'b0, reset_req}, 1);
    end

    // R9 sticky request
    idle(5); key(K_ARM); key(K_CNF); wr(A_CTL, 0);
    chk("R9 sticky", {31'b0, reset_req}, 1);
    do_reset(); chk("R9 cleared", {31'b0, reset_req}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  localparam logic [5:0] A_LIST [6] = '{A_CLO, A_CHI, A_PLO, A_PHI, A_GLB, A_CTL};
endmodule